// File: doc/BRIEF.md
# Interrupt Gating and Vector Unit

This block is the interrupt front end of a small microcontroller core. It collects pulse requests from up to fourteen on-chip peripherals, edge events from an eight-pin external port, and a software-interrupt request. It masks each one with its own enable bit and then with a global enable. When the CPU signals an instruction boundary and an unmasked request is present, the unit tells the CPU to load its program counter from one software-programmable vector. In the same cycle it captures the current PC so that execution can resume there.

Peripheral and pin events latch into sticky pending flags. Software clears them by writing ones. The software interrupt is level-driven: its enable bit is also its pending flag, and it stays set until software clears it. A return from interrupt sends the CPU back to the saved PC and re-enables interrupts. A variant of the return also loads the vector register with the address just past the return instruction, so the next interrupt resumes there.

Top module: `irqGateUnit`

## Requirements
- R1: After reset, `gie`, `vector`, `savedPc`, `periphPend`, `extPend`, `takeIrq` and `pcLoad` are all zero.
- R2: With `regWr` high, `regSel` selects the target register, and the write takes effect at the next clock edge. The codes are: 0 = vector high byte, 1 = vector low byte, 2 = peripheral enables, 3 = pin enables, 4 = pin polarity, 5 = configuration (bit 0 = global enable, bit 1 = software-interrupt enable), 6 = peripheral pending clear, 7 = pin pending clear.
- R3: A one-cycle pulse on bit i of `periphReq` sets `periphPend[i]` at the next edge. The flag holds until a write of a one to bit i with code 6. If a pulse and a clear of the same bit occur in one cycle, the flag ends up set.
- R4: Pin i sets `extPend[i]` at the clock edge after its level changes. It does so on a rising change when polarity bit i is 1, or on a falling change when it is 0. The opposite change has no effect. Writing a one to bit i with code 7 clears the flag.
- R5: `takeIrq` is high in a cycle only if `instrBoundary` and `gie` are high and at least one of these holds: an enabled pending flag is set, or `swiExec` is high with the software-interrupt enable set. In that cycle `pcLoad` is high and `pcNext` equals `vector`.
- R6: At the edge that ends a taken cycle, `savedPc` captures `curPc` and `gie` clears.
- R7: In a cycle with `retStrobe` high, `pcLoad` is high, `pcNext` equals `savedPc` and `takeIrq` is low. At the next edge `gie` is set.
- R8: A return with `retUpdateVec` high loads `vector` with `curPc + 1` at the next edge. A register write to a vector half in the same cycle wins for that half.
- R9: The software-interrupt enable is never cleared by hardware. An interrupt taken from it fires again after the return unless software clears the bit.
- R10: A pending flag whose enable bit is 0 causes no interrupt. The flag stays set, and it is taken once its enable is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphReq | input | 14 | Peripheral request pulses |
| extPins | input | 8 | External port pin levels |
| swiExec | input | 1 | CPU is executing the software-interrupt instruction |
| instrBoundary | input | 1 | CPU is at an instruction boundary |
| retStrobe | input | 1 | CPU is executing a return from interrupt |
| retUpdateVec | input | 1 | The return also writes the incremented PC into the vector |
| curPc | input | 16 | Current program counter |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regData | input | 14 | Register write data |
| takeIrq | output | 1 | Interrupt accepted this cycle |
| pcLoad | output | 1 | CPU must load `pcNext` |
| pcNext | output | 16 | Jump target: the vector or the saved PC |
| vector | output | 16 | Interrupt vector register |
| savedPc | output | 16 | Saved PC register |
| gie | output | 1 | Global interrupt enable |
| periphPend | output | 14 | Peripheral pending flags |
| extPend | output | 8 | Pin pending flags |

## Verification
The embedded properties check several rules on every cycle: an accepted interrupt always coincides with a boundary and an open global enable, a return always suppresses acceptance, and the global enable falls after a take and rises after a return. They also check that the saved PC captures the PC of the taken cycle, that pending flags never drop without a clear, and that the vector tracks `curPc + 1` on an updating return. Some behaviour only the bench scenarios can show: per-pin polarity selection, the re-firing of an uncleared software interrupt, and a masked flag being taken later once enabled. The same holds for a software write to a vector half beating the return update, and for the next interrupt resuming just past the updating return.

// File: rtl/irqPkg.sv
package irqPkg;

  typedef enum logic [2:0] {
    SEL_VEC_HI  = 3'd0,
    SEL_VEC_LO  = 3'd1,
    SEL_PER_EN  = 3'd2,
    SEL_EXT_EN  = 3'd3,
    SEL_EXT_POL = 3'd4,
    SEL_CFG     = 3'd5,
    SEL_PER_CLR = 3'd6,
    SEL_EXT_CLR = 3'd7
  } regSel_e;

  typedef struct packed {
    logic take;
    logic ret;
    logic retVec;
    logic wVecHi;
    logic wVecLo;
    logic wPerEn;
    logic wExtEn;
    logic wPol;
    logic wCfg;
    logic wPerClr;
    logic wExtClr;
  } ctrlStb_t;

endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrBoundary,
  input  logic       retStrobe,
  input  logic       retUpdateVec,
  input  logic       swiExec,
  input  logic       regWr,
  input  logic [2:0] regSel,
  input  logic       gie,
  input  logic       swEn,
  input  logic       srcHit,
  output ctrlStb_t   stb,
  output logic       takeIrq,
  output logic       pcLoad
);

  logic anyReq;
  regSel_e selE;

  assign selE   = regSel_e'(regSel);
  assign anyReq = srcHit | (swiExec & swEn);

  always_comb begin
    stb         = '0;
    stb.ret     = retStrobe;
    stb.retVec  = retStrobe & retUpdateVec;
    stb.take    = instrBoundary & gie & anyReq & ~retStrobe;
    stb.wVecHi  = regWr && (selE == SEL_VEC_HI);
    stb.wVecLo  = regWr && (selE == SEL_VEC_LO);
    stb.wPerEn  = regWr && (selE == SEL_PER_EN);
    stb.wExtEn  = regWr && (selE == SEL_EXT_EN);
    stb.wPol    = regWr && (selE == SEL_EXT_POL);
    stb.wCfg    = regWr && (selE == SEL_CFG);
    stb.wPerClr = regWr && (selE == SEL_PER_CLR);
    stb.wExtClr = regWr && (selE == SEL_EXT_CLR);
  end

  assign takeIrq = stb.take;
  assign pcLoad  = stb.take | stb.ret;

  // R5
  take_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (gie && instrBoundary));

  // R7
  ret_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |-> (!takeIrq && pcLoad));

endmodule

// File: rtl/irqData.sv
module irqData
  import irqPkg::*;
#(
  parameter int NPERIPH = 14,
  parameter int NPINS   = 8,
  parameter int PCW     = 16,
  parameter int DW      = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [NPERIPH-1:0] periphReq,
  input  logic [NPINS-1:0]   extPins,
  input  logic [PCW-1:0]     curPc,
  input  logic [DW-1:0]      regData,
  output logic               srcHit,
  output logic               gie,
  output logic               swEn,
  output logic [PCW-1:0]     pcNext,
  output logic [PCW-1:0]     vector,
  output logic [PCW-1:0]     savedPc,
  output logic [NPERIPH-1:0] periphPend,
  output logic [NPINS-1:0]   extPend
);

  localparam int HW = PCW / 2;

  logic [HW-1:0]      vecHi, vecLo;
  logic [NPERIPH-1:0] perEn, perClr;
  logic [NPINS-1:0]   extEn, extPol, extPrev, extEdge, extClr;
  logic [PCW-1:0]     incPc;

  assign incPc  = curPc + PCW'(1);
  assign vector = {vecHi, vecLo};
  assign pcNext = stb.ret ? savedPc : vector;
  assign perClr = stb.wPerClr ? regData[NPERIPH-1:0] : '0;
  assign extClr = stb.wExtClr ? regData[NPINS-1:0] : '0;
  assign srcHit = |(periphPend & perEn) | |(extPend & extEn);

  for (genvar i = 0; i < NPINS; i++) begin : g_edge
    assign extEdge[i] = extPol[i] ? (extPins[i] & ~extPrev[i])
                                  : (~extPins[i] & extPrev[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecHi      <= '0;
      vecLo      <= '0;
      savedPc    <= '0;
      gie        <= 1'b0;
      swEn       <= 1'b0;
      perEn      <= '0;
      extEn      <= '0;
      extPol     <= '0;
      extPrev    <= '0;
      periphPend <= '0;
      extPend    <= '0;
    end else begin
      if (stb.wVecHi)      vecHi <= regData[HW-1:0];
      else if (stb.retVec) vecHi <= incPc[PCW-1:HW];
      if (stb.wVecLo)      vecLo <= regData[HW-1:0];
      else if (stb.retVec) vecLo <= incPc[HW-1:0];
      if (stb.take) savedPc <= curPc;
      if (stb.take)      gie <= 1'b0;
      else if (stb.ret)  gie <= 1'b1;
      else if (stb.wCfg) gie <= regData[0];
      if (stb.wCfg)   swEn   <= regData[1];
      if (stb.wPerEn) perEn  <= regData[NPERIPH-1:0];
      if (stb.wExtEn) extEn  <= regData[NPINS-1:0];
      if (stb.wPol)   extPol <= regData[NPINS-1:0];
      extPrev    <= extPins;
      periphPend <= (periphPend & ~perClr) | periphReq;
      extPend    <= (extPend & ~extClr) | extEdge;
    end
  end

  // R6
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> !gie);

  // R6
  saved_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> (savedPc == $past(curPc)));

  // R7
  gie_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ret |=> gie);

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wPerClr |=> ((periphPend & $past(periphPend)) == $past(periphPend)));

  // R8
  vec_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.retVec && !stb.wVecLo) |=> (vector[HW-1:0] == $past(incPc[HW-1:0])));

endmodule

// File: rtl/irqGateUnit.sv
module irqGateUnit
  import irqPkg::*;
#(
  parameter int NPERIPH = 14,
  parameter int NPINS   = 8,
  parameter int PCW     = 16,
  parameter int DW      = (NPERIPH > PCW / 2) ? NPERIPH : PCW / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPERIPH-1:0] periphReq,
  input  logic [NPINS-1:0]   extPins,
  input  logic               swiExec,
  input  logic               instrBoundary,
  input  logic               retStrobe,
  input  logic               retUpdateVec,
  input  logic [PCW-1:0]     curPc,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [DW-1:0]      regData,
  output logic               takeIrq,
  output logic               pcLoad,
  output logic [PCW-1:0]     pcNext,
  output logic [PCW-1:0]     vector,
  output logic [PCW-1:0]     savedPc,
  output logic               gie,
  output logic [NPERIPH-1:0] periphPend,
  output logic [NPINS-1:0]   extPend
);

  ctrlStb_t stb;
  logic     srcHit;
  logic     swEn;

  irqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary),
    .retStrobe(retStrobe), .retUpdateVec(retUpdateVec), .swiExec(swiExec),
    .regWr(regWr), .regSel(regSel), .gie(gie), .swEn(swEn), .srcHit(srcHit),
    .stb(stb), .takeIrq(takeIrq), .pcLoad(pcLoad)
  );

  irqData #(.NPERIPH(NPERIPH), .NPINS(NPINS), .PCW(PCW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .periphReq(periphReq),
    .extPins(extPins), .curPc(curPc), .regData(regData), .srcHit(srcHit),
    .gie(gie), .swEn(swEn), .pcNext(pcNext), .vector(vector),
    .savedPc(savedPc), .periphPend(periphPend), .extPend(extPend)
  );

endmodule

// File: tb/tb_irqGateUnit.sv
module tb_irqGateUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] periphReq = '0;
  logic [7:0]  extPins = '0;
  logic        swiExec = 1'b0, instrBoundary = 1'b0;
  logic        retStrobe = 1'b0, retUpdateVec = 1'b0;
  logic [15:0] curPc = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regSel = '0;
  logic [13:0] regData = '0;
  logic        takeIrq, pcLoad, gie;
  logic [15:0] pcNext, vector, savedPc;
  logic [13:0] periphPend;
  logic [7:0]  extPend;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqGateUnit dut (.*);

  typedef struct packed {
    logic [13:0] pulse;
    logic [13:0] en;
    logic        expTake;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{14'h0001, 14'h0001, 1'b1},
    '{14'h0002, 14'h0001, 1'b0},
    '{14'h2000, 14'h3FFF, 1'b1},
    '{14'h0000, 14'h3FFF, 1'b0},
    '{14'h0A00, 14'h0800, 1'b1},
    '{14'h3FFF, 14'h0000, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic writeReg(logic [2:0] sel, logic [13:0] data);
    regWr = 1'b1; regSel = sel; regData = data;
    step();
    regWr = 1'b0;
  endtask

  task automatic boundary(string tag, logic expTake);
    instrBoundary = 1'b1; #1;
    chk(tag, takeIrq, expTake);
    step();
    instrBoundary = 1'b0;
  endtask

  task automatic doRet(logic upd, logic [15:0] pc);
    retStrobe = 1'b1; retUpdateVec = upd; curPc = pc;
    step();
    retStrobe = 1'b0; retUpdateVec = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 gie", gie, 0);
    chk("R1 take", takeIrq, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    step();
    chk("R1 vector", vector, 0);
    chk("R1 savedPc", savedPc, 0);
    chk("R1 pend", {periphPend, extPend}, 0);
    chk("R1 pcLoad", pcLoad, 0);

    // table: R3 latching and R5/R10 masking
    foreach (ROWS[i]) begin
      writeReg(3'd5, 14'h0);
      writeReg(3'd6, 14'h3FFF);
      writeReg(3'd2, ROWS[i].en);
      periphReq = ROWS[i].pulse;
      step();
      periphReq = '0;
      chk("R3 row pend", periphPend, ROWS[i].pulse);
      writeReg(3'd5, 14'h1);
      boundary("R5 R10 row take", ROWS[i].expTake);
    end
    writeReg(3'd5, 14'h0);
    writeReg(3'd6, 14'h3FFF);

    // R2 vector write
    writeReg(3'd0, 14'h12);
    writeReg(3'd1, 14'h34);
    chk("R2 vector", vector, 16'h1234);

    // R5/R6 take
    writeReg(3'd2, 14'h0008);
    periphReq = 14'h0008; step(); periphReq = '0;
    writeReg(3'd5, 14'h1);
    curPc = 16'h0100;
    instrBoundary = 1'b1; #1;
    chk("R5 take", takeIrq, 1);
    chk("R5 pcLoad", pcLoad, 1);
    chk("R5 pcNext", pcNext, 16'h1234);
    step(); instrBoundary = 1'b0;
    chk("R6 savedPc", savedPc, 16'h0100);
    chk("R6 gie", gie, 0);
    boundary("R5 no take gie low", 1'b0);

    // R7 plain return
    retStrobe = 1'b1; curPc = 16'h1240; #1;
    chk("R7 pcNext", pcNext, 16'h0100);
    chk("R7 pcLoad", pcLoad, 1);
    step(); retStrobe = 1'b0;
    chk("R7 gie", gie, 1);
    chk("R7 vector kept", vector, 16'h1234);
    writeReg(3'd6, 14'h0008);
    chk("R3 w1c", periphPend, 0);

    // R4 edges: pin0 rising, pin1 falling
    writeReg(3'd5, 14'h0);
    writeReg(3'd4, 14'h01);
    extPins = 8'h03; step();
    chk("R4 rise", extPend, 8'h01);
    extPins = 8'h00; step();
    chk("R4 fall", extPend, 8'h03);
    writeReg(3'd7, 14'h02);
    chk("R4 clear", extPend, 8'h01);

    // R8 updating return
    writeReg(3'd3, 14'h01);
    writeReg(3'd5, 14'h1);
    curPc = 16'h0200;
    boundary("R5 ext take", 1'b1);
    doRet(1'b1, 16'h1250);
    chk("R8 vector", vector, 16'h1251);
    curPc = 16'h0300;
    instrBoundary = 1'b1; #1;
    chk("R8 resume", pcNext, 16'h1251);
    step(); instrBoundary = 1'b0;
    retStrobe = 1'b1; retUpdateVec = 1'b1; curPc = 16'h1300;
    regWr = 1'b1; regSel = 3'd0; regData = 14'h00AB;
    step();
    retStrobe = 1'b0; retUpdateVec = 1'b0; regWr = 1'b0;
    chk("R8 write wins", vector, 16'hAB01);
    writeReg(3'd7, 14'hFF);

    // R9 software interrupt
    writeReg(3'd5, 14'h3);
    swiExec = 1'b1; curPc = 16'h0400;
    boundary("R9 swi take", 1'b1);
    doRet(1'b0, 16'h0400);
    curPc = 16'h0400;
    boundary("R9 swi refire", 1'b1);
    doRet(1'b0, 16'h0400);
    writeReg(3'd5, 14'h1);
    boundary("R9 swi cleared", 1'b0);
    swiExec = 1'b0;

    // R7 return blocks take; R10 masked then enabled
    writeReg(3'd2, 14'h0);
    periphReq = 14'h0010; step(); periphReq = '0;
    boundary("R10 masked", 1'b0);
    chk("R10 held", periphPend, 14'h0010);
    writeReg(3'd2, 14'h0010);
    retStrobe = 1'b1; instrBoundary = 1'b1; #1;
    chk("R7 ret blocks", takeIrq, 0);
    chk("R7 ret target", pcNext, 16'h0400);
    step(); retStrobe = 1'b0; instrBoundary = 1'b0;
    chk("R7 gie after", gie, 1);
    boundary("R10 enabled take", 1'b1);

    // R3 set beats clear
    periphReq = 14'h0020;
    regWr = 1'b1; regSel = 3'd6; regData = 14'h0030;
    step();
    periphReq = '0; regWr = 1'b0;
    chk("R3 set wins", periphPend, 14'h0020);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule